// File: doc/BRIEF.md
# Store drain buffer with load conflict check

This block sits between a core's store path and its data memory port. It accepts committed stores (byte address, 64-bit data, byte enables), keeps them in a small circular queue, and writes them to memory strictly oldest first through a request/grant handshake. An entry leaves the queue only in a cycle where its request is granted.

Every load is looked up against the stores still held, and against a store being accepted in the same cycle. The comparison uses only the doubleword part of the page offset, bits 11:3 of the byte address. Those bits are identical before and after translation, so the lookup can run on an untranslated load address. When some held store shares the load's page offset, the load must wait until the buffer has drained. The one exception is a bypass: the youngest store sharing the offset has the load's full doubleword address and its byte enables cover every byte the load asks for. The load then takes that store's data on its own byte lanes and does not wait.

The load side supplies a doubleword address (byte address bits 63:3) plus byte enables. The answer is combinational in the same cycle. The block does not translate addresses, cache data or raise exceptions.

Top module: `st_drain_buf`

## Requirements
- R1: After the asynchronous active-low reset the buffer is empty: stReady is 1, memReq is 0, and no load is stalled or forwarded.
- R2: stReady is 0 exactly when DEPTH (4) stores are held. A store offered while stReady is 0 is not stored and is never written to memory.
- R3: While the buffer is non-empty, memReq is 1 and memWe is 1, with memAddr, memWdata and memBe taken from the oldest entry. These stay unchanged until memGnt is seen with memReq. Entries reach memory in acceptance order, and each leaves after exactly one grant.
- R4: A store accepted (stValid with stReady) in the same cycle as a granted drain leaves the occupancy unchanged.
- R5: A valid load whose doubleword address matches a held store in byte-address bits 11:3 but differs in a higher bit gets ldStall = 1 and ldFwd = 0.
- R6: A valid load that matches no held store in bits 11:3 gets ldStall = 0 and ldFwd = 0.
- R7: Bypass: if the youngest held store matching in bits 11:3 has the same doubleword address (bits 63:3) and its byte enables include every bit of ldBe, then ldFwd = 1 and ldStall = 0. ldFwdData byte lane l (bits 8l+7:8l) equals that store's lane l where ldBe[l] = 1, and is 0 elsewhere.
- R8: A full-address match is not bypassed when a younger held store matches the load in bits 11:3 with a different upper address; the load stalls.
- R9: When the youngest full-address match does not cover all requested bytes, the load stalls, even if an older store covers them.
- R10: A store being accepted in the current cycle takes part in the lookup as the youngest entry.
- R11: With ldValid = 0, ldStall and ldFwd are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| stValid | input | 1 | A store is offered |
| stAddr | input | 64 | Store byte address |
| stData | input | 64 | Store data, lane-aligned |
| stBe | input | 8 | Store byte enables |
| stReady | output | 1 | Buffer can accept a store |
| ldValid | input | 1 | A load lookup is presented |
| ldDwAddr | input | 61 | Load doubleword address (byte address bits 63:3) |
| ldBe | input | 8 | Load byte enables |
| ldStall | output | 1 | Load must wait for the buffer to drain |
| ldFwd | output | 1 | Load takes its data from ldFwdData |
| ldFwdData | output | 64 | Forwarded bytes on the load's lanes |
| memReq | output | 1 | Drain request to memory |
| memWe | output | 1 | Write enable of the drain request |
| memAddr | output | 64 | Drain byte address |
| memWdata | output | 64 | Drain write data |
| memBe | output | 8 | Drain byte enables |
| memGnt | input | 1 | Memory grant for the drain request |

## Verification
On every cycle the assertions keep a shadow occupancy built only from accepted stores and granted drains. Against it they check that stReady and memReq follow the fill level, that a pending drain request holds its address, data and byte enables until granted, that stall and forward never coincide or appear without a valid load, and that forwarded data is zero outside the requested lanes. Which store a load is compared against, whether forwarding picks the youngest match, the alias and partial-coverage stalls, and the drain order all depend on sequences of stores, so only the bench's scenarios show them, with a scoreboard matching every granted drain to the store queued for it.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic push;   // a store is written into the slot at wrPtr this cycle
    logic empty;  // no entry held; drain outputs are parked at zero
  } sdbStrobe_t;

endpackage

// File: rtl/sdb_ctrl.sv
module sdb_ctrl
  import sdb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stValid,
  input  logic             memGnt,
  output sdbStrobe_t       strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [DEPTH-1:0] validQ,
  output logic             stReady,
  output logic             memReq
);

  logic [CNT_W-1:0] countQ;
  logic [DEPTH-1:0] validN;
  logic             full;
  logic             empty;
  logic             push;
  logic             pop;

  assign full    = (countQ == CNT_W'(DEPTH));
  assign empty   = (countQ == '0);
  // Ready depends on occupancy only, never on the grant of this cycle.
  assign stReady = !full;
  assign push    = stValid && !full;
  assign memReq  = !empty;
  assign pop     = !empty && memGnt;

  always_comb begin
    strobe = '{push: push, empty: empty};
  end

  always_comb begin
    validN = validQ;
    if (pop)  validN[rdPtr] = 1'b0;
    if (push) validN[wrPtr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      countQ <= '0;
      validQ <= '0;
    end else begin
      validQ <= validN;
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   countQ <= countQ + 1'b1;
        2'b01:   countQ <= countQ - 1'b1;
        default: countQ <= countQ;
      endcase
    end
  end

endmodule

// File: rtl/sdb_dp.sv
module sdb_dp
  import sdb_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 64,
  parameter int PAGE_BITS = 12,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int LANES    = DATA_W / 8,
  localparam int LANE_W   = $clog2(LANES),
  localparam int DW_W     = ADDR_W - LANE_W,
  localparam int OFF_W    = PAGE_BITS - LANE_W
) (
  input  logic              clk,
  input  sdbStrobe_t        strobe,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [DEPTH-1:0]  validQ,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic [LANES-1:0]  stBe,
  input  logic              ldValid,
  input  logic [DW_W-1:0]   ldDwAddr,
  input  logic [LANES-1:0]  ldBe,
  output logic              ldStall,
  output logic              ldFwd,
  output logic [DATA_W-1:0] ldFwdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [LANES-1:0]  memBe
);

  logic [ADDR_W-1:0] addrQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];
  logic [LANES-1:0]  beQ   [DEPTH];

  // Entry storage: written at the tail, never reset (validity lives in control).
  always_ff @(posedge clk) begin
    if (strobe.push) begin
      addrQ[wrPtr] <= stAddr;
      dataQ[wrPtr] <= stData;
      beQ[wrPtr]   <= stBe;
    end
  end

  // Drain port: head entry, parked at zero while empty.
  assign memAddr  = strobe.empty ? '0 : addrQ[rdPtr];
  assign memWdata = strobe.empty ? '0 : dataQ[rdPtr];
  assign memBe    = strobe.empty ? '0 : beQ[rdPtr];

  // Lane mask from the load byte enables.
  logic [DATA_W-1:0] ldMask;
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_mask
      assign ldMask[l*8 +: 8] = {8{ldBe[l]}};
    end
  endgenerate

  // Age-ordered scan: head first, so the last offset match seen is the youngest.
  logic              offHit;
  logic              youngFull;
  logic [LANES-1:0]  youngBe;
  logic [DATA_W-1:0] youngData;

  always_comb begin : lookup
    logic [PTR_W-1:0] idx;
    offHit    = 1'b0;
    youngFull = 1'b0;
    youngBe   = '0;
    youngData = '0;
    idx       = rdPtr;
    for (int k = 0; k < DEPTH; k++) begin
      idx = rdPtr + PTR_W'(k);
      if (validQ[idx] && (addrQ[idx][PAGE_BITS-1:LANE_W] == ldDwAddr[OFF_W-1:0])) begin
        offHit    = 1'b1;
        youngFull = (addrQ[idx][ADDR_W-1:LANE_W] == ldDwAddr);
        youngBe   = beQ[idx];
        youngData = dataQ[idx];
      end
    end
    // A store entering this cycle is younger than every held entry.
    if (strobe.push && (stAddr[PAGE_BITS-1:LANE_W] == ldDwAddr[OFF_W-1:0])) begin
      offHit    = 1'b1;
      youngFull = (stAddr[ADDR_W-1:LANE_W] == ldDwAddr);
      youngBe   = stBe;
      youngData = stData;
    end
  end

  logic covers;
  logic canBypass;
  assign covers    = ((ldBe & ~youngBe) == '0);
  assign canBypass = offHit && youngFull && covers;

  assign ldFwd     = ldValid && canBypass;
  assign ldStall   = ldValid && offHit && !canBypass;
  assign ldFwdData = ldFwd ? (youngData & ldMask) : '0;

endmodule

// File: rtl/st_drain_buf.sv
module st_drain_buf
  import sdb_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 64,
  parameter int PAGE_BITS = 12,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int LANES    = DATA_W / 8,
  localparam int DW_W     = ADDR_W - $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic [LANES-1:0]  stBe,
  output logic              stReady,
  input  logic              ldValid,
  input  logic [DW_W-1:0]   ldDwAddr,
  input  logic [LANES-1:0]  ldBe,
  output logic              ldStall,
  output logic              ldFwd,
  output logic [DATA_W-1:0] ldFwdData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [LANES-1:0]  memBe,
  input  logic              memGnt
);

  sdbStrobe_t       strobe;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [DEPTH-1:0] validQ;

  sdb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .stValid (stValid),
    .memGnt  (memGnt),
    .strobe  (strobe),
    .wrPtr   (wrPtr),
    .rdPtr   (rdPtr),
    .validQ  (validQ),
    .stReady (stReady),
    .memReq  (memReq)
  );

  sdb_dp #(
    .DEPTH     (DEPTH),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BITS (PAGE_BITS)
  ) u_dp (
    .clk       (clk),
    .strobe    (strobe),
    .wrPtr     (wrPtr),
    .rdPtr     (rdPtr),
    .validQ    (validQ),
    .stAddr    (stAddr),
    .stData    (stData),
    .stBe      (stBe),
    .ldValid   (ldValid),
    .ldDwAddr  (ldDwAddr),
    .ldBe      (ldBe),
    .ldStall   (ldStall),
    .ldFwd     (ldFwd),
    .ldFwdData (ldFwdData),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memBe     (memBe)
  );

  // Every drain request is a write.
  assign memWe = memReq;

endmodule

// File: rtl/sdb_checker.sv
module sdb_checker #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              stValid,
  input logic              stReady,
  input logic              ldValid,
  input logic [LANES-1:0]  ldBe,
  input logic              ldStall,
  input logic              ldFwd,
  input logic [DATA_W-1:0] ldFwdData,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic [LANES-1:0]  memBe,
  input logic              memGnt
);

  // Shadow occupancy built from port handshakes only.
  logic [CW-1:0] fill;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fill <= '0;
    else begin
      case ({stValid && stReady, memReq && memGnt})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  logic [DATA_W-1:0] laneMask;
  always_comb begin
    for (int l = 0; l < LANES; l++) laneMask[l*8 +: 8] = {8{ldBe[l]}};
  end

  p_ready_fill_r2: assert property (@(posedge clk) disable iff (!rstN)
    stReady == (fill != CW'(DEPTH)));

  p_req_fill_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq == (fill != '0));

  p_hold_until_gnt_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> (memReq && $stable(memAddr) && $stable(memWdata) && $stable(memBe)));

  p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    fill <= CW'(DEPTH));

  p_no_ld_answer_r11: assert property (@(posedge clk) disable iff (!rstN)
    !ldValid |-> (!ldStall && !ldFwd));

  p_stall_fwd_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(ldStall && ldFwd));

  p_fwd_lanes_r7: assert property (@(posedge clk) disable iff (!rstN)
    ldFwd |-> ((ldFwdData & ~laneMask) == '0));

endmodule

bind st_drain_buf sdb_checker #(
  .DEPTH  (DEPTH),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/test_st_drain_buf.sv
`timescale 1ns/1ps
module test_st_drain_buf;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stValid = 1'b0;
  logic [63:0] stAddr = '0;
  logic [63:0] stData = '0;
  logic [7:0]  stBe = '0;
  logic        stReady;
  logic        ldValid = 1'b0;
  logic [60:0] ldDwAddr = '0;
  logic [7:0]  ldBe = '0;
  logic        ldStall;
  logic        ldFwd;
  logic [63:0] ldFwdData;
  logic        memReq;
  logic        memWe;
  logic [63:0] memAddr;
  logic [63:0] memWdata;
  logic [7:0]  memBe;
  logic        memGnt = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  st_drain_buf i_st_drain_buf (.*);

  typedef struct packed { logic [63:0] a; logic [63:0] d; logic [7:0] b; } stItem_t;
  stItem_t expQ[$];

  int nChecks = 0;
  int nFail   = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mask(logic [7:0] be);
    logic [63:0] m;
    for (int l = 0; l < 8; l++) m[l*8 +: 8] = be[l] ? 8'hFF : 8'h00;
    return m;
  endfunction

  // Driver: offer a store, wait for acceptance, record the expected drain.
  task automatic pushStore(logic [63:0] a, logic [63:0] d, logic [7:0] b);
    @(negedge clk);
    stValid = 1'b1; stAddr = a; stData = d; stBe = b;
    #3;
    while (!stReady) begin @(negedge clk); #3; end
    expQ.push_back('{a: a, d: d, b: b});
    @(negedge clk);
    stValid = 1'b0;
  endtask

  task automatic loadCheck(string tag, logic v, logic [63:0] a, logic [7:0] b,
                           logic eStall, logic eFwd, logic [63:0] eData);
    @(negedge clk);
    ldValid = v; ldDwAddr = a[63:3]; ldBe = b;
    #3;
    chk({tag, " ldStall"}, 64'(ldStall), 64'(eStall));
    chk({tag, " ldFwd"}, 64'(ldFwd), 64'(eFwd));
    chk({tag, " ldFwdData"}, ldFwdData, eData);
    ldValid = 1'b0;
  endtask

  task automatic drainAll();
    @(negedge clk);
    memGnt = 1'b1;
    #3;
    while (memReq) begin @(negedge clk); #3; end
    memGnt = 1'b0;
    chk("R3 drained memReq", 64'(memReq), 64'd0);
    chk("R2 R3 nothing left expected", 64'(expQ.size()), 64'd0);
  endtask

  // Monitor: compare every granted drain with the oldest expected store.
  always begin
    @(negedge clk);
    #2;
    if (rstN && memReq) begin
      chk("R3 memWe", 64'(memWe), 64'd1);
      if (memGnt) begin
        if (expQ.size() == 0) begin
          nChecks++; nFail++;
          $display("FAIL R3 unexpected drain actual=%h expected=none", memAddr);
        end else begin
          stItem_t e;
          e = expQ.pop_front();
          chk("R3 drain addr", memAddr, e.a);
          chk("R3 drain data", memWdata, e.d);
          chk("R3 drain be", 64'(memBe), 64'(e.b));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  localparam logic [63:0] A  = 64'h0000_0000_1000_0108;
  localparam logic [63:0] D1 = 64'h1122_3344_5566_7788;
  localparam logic [63:0] D2 = 64'hAABB_CCDD_EEFF_0011;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #3;
    chk("R1 stReady", 64'(stReady), 64'd1);
    chk("R1 memReq", 64'(memReq), 64'd0);
    chk("R1 ldStall", 64'(ldStall), 64'd0);

    // R3: request held without grant
    pushStore(64'h0000_0000_0000_0040, 64'hDEAD_BEEF_0000_0001, 8'h0F);
    repeat (2) begin
      @(negedge clk); #3;
      chk("R3 hold memReq", 64'(memReq), 64'd1);
      chk("R3 hold memAddr", memAddr, 64'h40);
    end
    drainAll();

    // R2: fill, then offer one more while not ready
    for (int i = 0; i < 4; i++) pushStore(64'h100 + 64'(i*8), 64'hA0 + 64'(i), 8'hFF);
    #3;
    chk("R2 stReady full", 64'(stReady), 64'd0);
    @(negedge clk);
    stValid = 1'b1; stAddr = 64'h900; stData = 64'hBAD; stBe = 8'hFF;
    repeat (2) @(negedge clk);
    stValid = 1'b0;
    drainAll();

    // R4: accept and drain in the same cycle
    for (int i = 0; i < 3; i++) pushStore(64'h200 + 64'(i*8), 64'hB0 + 64'(i), 8'h33);
    @(negedge clk);
    stValid = 1'b1; stAddr = 64'h218; stData = 64'hB3; stBe = 8'h33; memGnt = 1'b1;
    #3;
    chk("R4 ready before combined cycle", 64'(stReady), 64'd1);
    expQ.push_back('{a: 64'h218, d: 64'hB3, b: 8'h33});
    @(negedge clk);
    stValid = 1'b0; memGnt = 1'b0;
    #3;
    chk("R4 occupancy unchanged (ready)", 64'(stReady), 64'd1);
    pushStore(64'h220, 64'hB4, 8'h33);
    #3;
    chk("R4 one more fills buffer", 64'(stReady), 64'd0);
    drainAll();

    // R3: order under an alternating grant
    fork
      begin
        for (int i = 0; i < 6; i++) pushStore(64'h3000 + 64'(i*16), 64'hC000 + 64'(i), 8'(8'h1 << i));
      end
      begin
        repeat (40) begin @(negedge clk); memGnt = ~memGnt; end
        memGnt = 1'b0;
      end
    join
    drainAll();

    // Lookup scenarios, no grant
    pushStore(A, D1, 8'hFF);
    loadCheck("R7 bypass upper lanes", 1'b1, A, 8'hF0, 1'b0, 1'b1, D1 & mask(8'hF0));
    loadCheck("R5 alias upper addr", 1'b1, 64'h0000_0000_2000_0108, 8'h01, 1'b1, 1'b0, 64'd0);
    loadCheck("R5 alias bit 12", 1'b1, 64'h0000_0000_1000_1108, 8'hFF, 1'b1, 1'b0, 64'd0);
    loadCheck("R6 other doubleword", 1'b1, 64'h0000_0000_1000_0110, 8'hFF, 1'b0, 1'b0, 64'd0);
    loadCheck("R11 no valid load", 1'b0, 64'h0000_0000_2000_0108, 8'hFF, 1'b0, 1'b0, 64'd0);
    pushStore(A, D2, 8'h0F);
    loadCheck("R7 youngest wins", 1'b1, A, 8'h0F, 1'b0, 1'b1, D2 & mask(8'h0F));
    loadCheck("R9 partial coverage", 1'b1, A, 8'hF0, 1'b1, 1'b0, 64'd0);
    pushStore(64'h0000_0000_3000_0108, 64'h77, 8'hFF);
    loadCheck("R8 younger alias", 1'b1, A, 8'h0F, 1'b1, 1'b0, 64'd0);
    drainAll();

    // R10: store entering this cycle
    @(negedge clk);
    stValid = 1'b1; stAddr = 64'h4000_0200; stData = D1; stBe = 8'hFF;
    ldValid = 1'b1; ldDwAddr = 61'(64'h4000_0200 >> 3); ldBe = 8'h0C;
    #3;
    chk("R10 bypass from incoming fwd", 64'(ldFwd), 64'd1);
    chk("R10 bypass from incoming data", ldFwdData, D1 & mask(8'h0C));
    expQ.push_back('{a: 64'h4000_0200, d: D1, b: 8'hFF});
    @(negedge clk);
    stAddr = 64'h5000_0200; stData = D2;
    #3;
    chk("R10 incoming alias stalls", 64'(ldStall), 64'd1);
    expQ.push_back('{a: 64'h5000_0200, d: D2, b: 8'hFF});
    @(negedge clk);
    stValid = 1'b0; ldValid = 1'b0;
    drainAll();

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule